// File: doc/BRIEF.md
# Memory-Resident Counter-Program Interpreter

This block is a small stored-program machine. A single word-addressed register array holds both the program and its data, and the program counter is an ordinary word of that array: register 1. After a start strobe the machine reads register 1 to find the current instruction. It then fetches the opcode word at that address, reads the operand words that follow the opcode, and executes the instruction. Last, it writes the next instruction address back into register 1. Because the program counter is plain memory, a program can read it or overwrite it.

There are four operations. HALT stops the machine. INC adds one to a register. DEC subtracts one from a register but never goes below zero. JZ jumps when a tested register is zero. Before a run, a host fills the array through a preload port. While the machine runs it reports nothing. When it stops, the host checks the halted and error flags and reads any word back through a debug read port.

Top module: `ctr_prog_interp`

## Requirements
- R1: After reset, `halted` and `error` are both 0 and the machine is idle. Register contents are not reset.
- R2: When `load_en` is high and the machine is idle or halted, `load_data` is written to register `load_addr`. While the machine is running, `load_en` is ignored. `dbg_data` returns the word at `dbg_addr` one clock after the address is presented.
- R3: After a `start` pulse, the first opcode is fetched from the address held in register 1. Opcodes are encoded as 0 = HALT, 1 = INC, 2 = DEC, 3 = JZ.
- R4: INC r (opcode 1, followed by the operand word r) adds 1 to register r, modulo 2^16. Register 1 then holds the opcode address + 2.
- R5: DEC r (opcode 2, followed by the operand word r) subtracts 1 from register r. If register r is 0, it stays 0. Register 1 then holds the opcode address + 2.
- R6: JZ r,z (opcode 3, followed by the operand words r and then z) loads z into register 1 when register r is zero. Otherwise register 1 holds the opcode address + 3.
- R7: HALT sets `halted` = 1 and `error` = 0 and leaves register 1 at the address of the HALT opcode. The flag stays set until the next `start`.
- R8: An opcode word greater than 3 sets both `error` and `halted` to 1. Register 1 is left at the address of the bad opcode.
- R9: With the words 3,18,15,2,18,1,19,3,15,5,0 at addresses 5 to 15 and register 1 = 5, the program adds register 18 into register 19. It leaves register 18 at 0 and stops cleanly with register 1 = 15.
- R10: A `start` pulse from the halted state clears `halted` and `error` at the next clock edge and runs again from the address in register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe; honoured only when not running |
| load_addr | input | 5 | Preload register number |
| load_data | input | 16 | Preload word |
| start | input | 1 | Begin execution at the address held in register 1 |
| dbg_addr | input | 5 | Debug read register number |
| dbg_data | output | 16 | Registered debug read data, one clock after `dbg_addr` |
| halted | output | 1 | Machine has stopped |
| error | output | 1 | Machine stopped on an undefined opcode |

## Verification
The move program is run with several pairs of source and destination values. A zero source takes the JZ branch on its first test. Source values of 1 and 5 exercise single and repeated loop iterations. A non-zero destination shows that the program adds rather than overwrites. A destination near 0xFFFF shows that INC wraps. Directed programs cover the remaining cases one at a time: a JZ that is not taken, a JZ that is taken past a poisoned word, a DEC on a zero register, a bad opcode, a restart from the halted state, and a preload attempted while the machine is running.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  typedef enum logic [1:0] {
    OP_HALT = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2,
    OP_JZ   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOADPC,
    ST_FETCH,
    ST_DECODE,
    ST_OPERAND1,
    ST_OPERAND2,
    ST_EXECUTE,
    ST_HALTED
  } state_e;

endpackage

// File: rtl/ctr_regfile.sv
module ctr_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  // No reset on the array so it maps onto block RAM; reads are read-first.
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/ctr_seq.sv
module ctr_seq
  import ctr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int PC_ADDR  = 1,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              we,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              running,
  output logic              halted,
  output logic              error
);

  localparam logic [DATA_W-1:0] MAX_OP = DATA_W'(3);
  localparam logic [ADDR_W-1:0] PC_REG = ADDR_W'(PC_ADDR);

  state_e            state;
  op_e               op_q;
  logic [DATA_W-1:0] pc_q;
  logic [ADDR_W-1:0] reg_q;
  logic              zero_q;

  logic [DATA_W-1:0] pc_plus1, pc_plus2, pc_plus3;
  assign pc_plus1 = pc_q + DATA_W'(1);
  assign pc_plus2 = pc_q + DATA_W'(2);
  assign pc_plus3 = pc_q + DATA_W'(3);

  assign running = (state != ST_IDLE) && (state != ST_HALTED);

  // One array access per state: a read issued here returns data in the next state.
  always_comb begin
    rd_addr = '0;
    we      = 1'b0;
    wr_addr = reg_q;
    wr_data = '0;
    case (state)
      ST_LOADPC:   rd_addr = PC_REG;
      ST_FETCH:    rd_addr = rd_data[ADDR_W-1:0];
      ST_DECODE:   rd_addr = pc_plus1[ADDR_W-1:0];
      ST_OPERAND1: rd_addr = rd_data[ADDR_W-1:0];
      ST_OPERAND2: begin
        rd_addr = pc_plus2[ADDR_W-1:0];
        if (op_q != OP_JZ) begin
          we      = 1'b1;
          wr_addr = reg_q;
          if (op_q == OP_INC)        wr_data = rd_data + DATA_W'(1);
          else if (rd_data == '0)    wr_data = '0;
          else                       wr_data = rd_data - DATA_W'(1);
        end
      end
      ST_EXECUTE: begin
        we      = 1'b1;
        wr_addr = PC_REG;
        if (op_q == OP_JZ) wr_data = zero_q ? rd_data : pc_plus3;
        else               wr_data = pc_plus2;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= OP_HALT;
      pc_q   <= '0;
      reg_q  <= '0;
      zero_q <= 1'b0;
      halted <= 1'b0;
      error  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_HALTED: begin
          if (start) begin
            state  <= ST_LOADPC;
            halted <= 1'b0;
            error  <= 1'b0;
          end
        end
        ST_LOADPC: state <= ST_FETCH;
        ST_FETCH: begin
          pc_q  <= rd_data;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          if (rd_data == '0) begin
            halted <= 1'b1;
            state  <= ST_HALTED;
          end else if (rd_data > MAX_OP) begin
            halted <= 1'b1;
            error  <= 1'b1;
            state  <= ST_HALTED;
          end else begin
            op_q  <= op_e'(rd_data[1:0]);
            state <= ST_OPERAND1;
          end
        end
        ST_OPERAND1: begin
          reg_q <= rd_data[ADDR_W-1:0];
          state <= ST_OPERAND2;
        end
        ST_OPERAND2: begin
          zero_q <= (rd_data == '0);
          state  <= ST_EXECUTE;
        end
        ST_EXECUTE: state <= ST_LOADPC;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // R2: no array write from the sequencer while stopped (preload owns the port)
  a_r2_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !running |-> !we);

  // R7: a stop is held until the next start
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> halted);

  // R7: stopping never follows a write, so the counter word stays at the stop address
  a_r7_halt_no_write: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> !$past(we));

  // R8: an error always comes with a stop
  a_r8_error_halts: assert property (@(posedge clk) disable iff (rst)
    error |-> halted);

endmodule

// File: rtl/ctr_prog_interp.sv
module ctr_prog_interp #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int PC_ADDR  = 1,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              start,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              halted,
  output logic              error
);

  logic [ADDR_W-1:0] seq_raddr, seq_waddr, mem_waddr;
  logic [DATA_W-1:0] seq_rdata, seq_wdata, mem_wdata;
  logic              seq_we, mem_we, running;

  // The host preload writes only while the sequencer is stopped.
  assign mem_we    = seq_we | (load_en & ~running);
  assign mem_waddr = seq_we ? seq_waddr : load_addr;
  assign mem_wdata = seq_we ? seq_wdata : load_data;

  ctr_regfile #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) regs_i (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .raddr_a(seq_raddr),
    .rdata_a(seq_rdata),
    .raddr_b(dbg_addr),
    .rdata_b(dbg_data)
  );

  ctr_seq #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .PC_ADDR (PC_ADDR)
  ) seq_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .rd_addr(seq_raddr),
    .rd_data(seq_rdata),
    .we     (seq_we),
    .wr_addr(seq_waddr),
    .wr_data(seq_wdata),
    .running(running),
    .halted (halted),
    .error  (error)
  );

endmodule

// File: tb/ctr_prog_interp_tb_top.sv
module ctr_prog_interp_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [4:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic        start = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic [15:0] dbg_data;
  logic        halted, error;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctr_prog_interp dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .start(start), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .halted(halted), .error(error)
  );

  localparam logic [15:0] MOVE_PROG [11] = '{16'd3, 16'd18, 16'd15, 16'd2, 16'd18,
                                           16'd1, 16'd19, 16'd3, 16'd15, 16'd5, 16'd0};
  // {source, destination, expected destination}
  localparam logic [15:0] VEC [5][3] = '{
    '{16'd0, 16'd0,     16'd0},
    '{16'd1, 16'd0,     16'd1},
    '{16'd5, 16'd0,     16'd5},
    '{16'd7, 16'd10,    16'd17},
    '{16'd3, 16'hFFFE,  16'h0001}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = 5'(a); load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic peek(input int a, output logic [15:0] v);
    @(negedge clk);
    dbg_addr = 5'(a);
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic go();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_halt(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (halted) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic load_move(input logic [15:0] src, input logic [15:0] dst);
    put(1, 16'd5);
    for (int i = 0; i < 11; i++) put(5 + i, MOVE_PROG[i]);
    put(18, src);
    put(19, dst);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 halted after reset", 16'(halted), 16'd0);
    chk("R1 error after reset", 16'(error), 16'd0);

    // R9 / R3 / R4 / R5 / R6: move program, table walk
    for (int k = 0; k < 5; k++) begin
      load_move(VEC[k][0], VEC[k][1]);
      go();
      wait_halt(ok);
      chk("R9 halted", 16'(ok), 16'd1);
      chk("R9 clean stop", 16'(error), 16'd0);
      peek(18, v); chk("R9 source cleared", v, 16'd0);
      peek(19, v); chk("R9 destination sum", v, VEC[k][2]);
      peek(1, v);  chk("R9 R3 stop address", v, 16'd15);
    end

    // R4 wrap, R5 floor, R6 not taken, R7 halt address
    put(1, 16'd5);
    put(5, 16'd1); put(6, 16'd20);
    put(7, 16'd2); put(8, 16'd21);
    put(9, 16'd3); put(10, 16'd22); put(11, 16'd30);
    put(12, 16'd0);
    put(20, 16'hFFFF); put(21, 16'd0); put(22, 16'd4);
    go(); wait_halt(ok);
    peek(20, v); chk("R4 INC wraps", v, 16'd0);
    peek(21, v); chk("R5 DEC of zero", v, 16'd0);
    peek(22, v); chk("R6 tested reg unchanged", v, 16'd4);
    peek(1, v);  chk("R6 not-taken skip / R7 pc", v, 16'd12);
    chk("R7 halted", 16'(halted), 16'd1);
    chk("R7 no error", 16'(error), 16'd0);

    // R6 taken, a poisoned word at 8 would error if skipped wrong
    put(1, 16'd5);
    put(5, 16'd3); put(6, 16'd22); put(7, 16'd10);
    put(8, 16'd7); put(10, 16'd0); put(22, 16'd0);
    go(); wait_halt(ok);
    peek(1, v); chk("R6 taken target", v, 16'd10);
    chk("R6 taken no error", 16'(error), 16'd0);

    // R8 bad opcode
    put(1, 16'd5); put(5, 16'd9);
    go(); wait_halt(ok);
    chk("R8 error set", 16'(error), 16'd1);
    chk("R8 halted set", 16'(halted), 16'd1);
    peek(1, v); chk("R8 pc at bad opcode", v, 16'd5);

    // R10 restart from halted
    put(5, 16'd0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 halted cleared", 16'(halted), 16'd0);
    chk("R10 error cleared", 16'(error), 16'd0);
    wait_halt(ok);
    chk("R10 stops clean", 16'(error), 16'd0);
    peek(1, v); chk("R10 pc", v, 16'd5);

    // R2 preload, debug read, and preload ignored while running
    put(25, 16'h1234);
    peek(25, v); chk("R2 debug read", v, 16'h1234);
    load_move(16'd9, 16'd0);
    go();
    put(25, 16'hBEEF);
    wait_halt(ok);
    peek(25, v); chk("R2 load ignored while running", v, 16'h1234);
    peek(19, v); chk("R2 R9 run result", v, 16'd9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule